// File: doc/BRIEF.md
# Line Clock Status Register Slave

This block is the bus-facing register of a mains-rate clock peripheral. It answers a single fixed word address and holds a two-bit status word. Bit 6 is an interrupt enable, which is passed on to a separate interrupt sequencer. Bit 7 is an event monitor. The monitor is set whenever a line-frequency event arrives, so software can poll it or use it to confirm that an interrupt came from this source.

A raw mains-derived waveform enters asynchronously. Two flops resynchronise it, and a rising-edge detector turns it into a pulse one clock wide. That pulse occurs once per mains period, which is 20 ms at 50 Hz or 16.67 ms at 60 Hz.

Bus transfers use a master-sync handshake:

- The master presents an address and a direction bit, then raises master sync.
- The block acts once, on the first cycle it is selected.
- After a programmable number of cycles it answers with slave-sync.
- It holds slave-sync until master sync falls.

Top module: `lck_status_top`

## Requirements
- R1: The block is selected only while `bus_msyn` is high and address bits 17:1 equal those of octal 777546. Address bit 0 is ignored. A transfer to any other word address changes no state and never raises `bus_ssyn`.
- R2: On the first selected cycle of a write (`bus_wr`=1), the enable bit is loaded from `wdat6` at the next clock edge.
- R3: On that first write cycle, `wdat7`=0 clears the monitor bit. `wdat7`=1 leaves it unchanged.
- R4: A rising edge on `line_raw` produces exactly one `line_pulse` cycle. The pulse is high in the cycle after the second clock edge that samples the new level. A level held high produces no further pulses.
- R5: A `line_pulse` sets the monitor bit at the following clock edge.
- R6: If a line pulse coincides with a clearing write, the monitor bit ends up set.
- R7: `bus_init` clears the enable bit and sets the monitor bit at the next edge. It takes priority over a write in the same cycle.
- R8: During a selected read, `rdat6` shows the enable bit and `rdat7` shows the monitor bit. At all other times both are 0.
- R9: `bus_ssyn` rises after SSYN_DLY clock edges of continuous selection, counting the first edge. It stays high while selected and falls one edge after master sync drops.
- R10: After `rst_n` is released, the enable bit is 0, the monitor bit is 1, and `bus_ssyn` and `line_pulse` are low.
- R11: A read transfer (`bus_wr`=0) leaves both status bits unchanged.
- R12: `irq_enable` always equals the stored enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 18 | Byte address of the transfer |
| bus_wr | input | 1 | 1 = write (master to slave), 0 = read |
| bus_msyn | input | 1 | Master sync |
| bus_init | input | 1 | Bus initialise, synchronous |
| wdat6 | input | 1 | Write data bit 6 |
| wdat7 | input | 1 | Write data bit 7 |
| line_raw | input | 1 | Raw line-frequency waveform, asynchronous |
| rdat6 | output | 1 | Read data bit 6 |
| rdat7 | output | 1 | Read data bit 7 |
| bus_ssyn | output | 1 | Slave sync |
| line_pulse | output | 1 | One-cycle line event pulse |
| irq_enable | output | 1 | Enable bit to the interrupt sequencer |

## Verification
Each result is due at a fixed point after its stimulus:

- Read data is combinational and is checked in the same cycle that master sync is driven.
- A status-bit update or an `irq_enable` change is checked one edge later.
- Slave-sync is checked for low on each of the first SSYN_DLY-1 selected edges and for high after the SSYN_DLY-th.
- `line_pulse` is checked low after the first edge that samples a new line level, high after the second, and low after the third.

Inputs are driven one nanosecond after a rising edge. Every expectation is queued at that moment, and the monitor compares it at the following falling edge, so each check lands in exactly the cycle computed for it.

// File: rtl/lck_pkg.sv
package lck_pkg;

    // stored status word: enable (bit 6) and event monitor (bit 7)
    typedef struct packed {
        logic ie;
        logic mon;
    } lck_stat_t;

    // line input resynchroniser and edge history
    typedef struct packed {
        logic s0;
        logic s1;
        logic prev;
    } lck_sync_t;

    localparam lck_stat_t LCK_STAT_RST = '{ie: 1'b0, mon: 1'b1};

endpackage

// File: rtl/lck_addr_match.sv
module lck_addr_match #(
    parameter int                ADDR_W   = 18,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 18'o777546
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              msyn,
    output logic              sel
);
    // bit 0 selects a byte and is excluded from the compare
    localparam logic [ADDR_W-1:0] MATCH_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

    always_comb begin
        sel = msyn && (((addr ^ DEV_ADDR) & MATCH_MASK) == '0);
    end
endmodule

// File: rtl/lck_ssyn_timer.sv
module lck_ssyn_timer #(
    parameter int SSYN_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic first,
    output logic ssyn
);
    localparam int CW = $clog2(SSYN_DLY + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SSYN_DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!sel)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + CW'(1);
        first = sel && (cnt_q == '0);
        ssyn  = (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    ssyn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !ssyn);

    // R9
    ssyn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssyn && sel) |=> ssyn);
endmodule

// File: rtl/lck_line_edge.sv
module lck_line_edge
    import lck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic pulse
);
    lck_sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s0   = line_raw;
        sy_d.s1   = sy_q.s0;
        sy_d.prev = sy_q.s1;
        pulse     = sy_q.s1 && !sy_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R4
    pulse_from_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(line_raw, 2));
endmodule

// File: rtl/lck_stat_reg.sv
module lck_stat_reg
    import lck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic first,
    input  logic sel,
    input  logic is_wr,
    input  logic wd6,
    input  logic wd7,
    input  logic pulse,
    output logic ie,
    output logic rd6,
    output logic rd7
);
    lck_stat_t st_d, st_q;
    logic      do_wr;

    always_comb begin
        do_wr = first && is_wr;
        st_d  = st_q;
        if (init) begin
            st_d = LCK_STAT_RST;
        end else begin
            if (do_wr) begin
                st_d.ie = wd6;
                if (!wd7) st_d.mon = 1'b0;
            end
            // event set outranks a clearing write
            if (pulse) st_d.mon = 1'b1;
        end
        ie  = st_q.ie;
        rd6 = sel && !is_wr && st_q.ie;
        rd7 = sel && !is_wr && st_q.mon;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LCK_STAT_RST;
        else        st_q <= st_d;
    end

    // R7
    init_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!st_q.ie && st_q.mon));

    // R5
    pulse_sets_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> st_q.mon);

    // R2
    wr_loads_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first && is_wr && !init) |=> (st_q.ie == $past(wd6)));

    // R3
    wr_clears_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first && is_wr && !wd7 && !pulse && !init) |=> !st_q.mon);
endmodule

// File: rtl/lck_status_top.sv
module lck_status_top #(
    parameter int                ADDR_W   = 18,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 18'o777546,
    parameter int                SSYN_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_msyn,
    input  logic              bus_init,
    input  logic              wdat6,
    input  logic              wdat7,
    input  logic              line_raw,
    output logic              rdat6,
    output logic              rdat7,
    output logic              bus_ssyn,
    output logic              line_pulse,
    output logic              irq_enable
);
    logic sel, first;

    lck_addr_match #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_match (
        .addr (bus_addr),
        .msyn (bus_msyn),
        .sel  (sel)
    );

    lck_ssyn_timer #(.SSYN_DLY(SSYN_DLY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .first (first),
        .ssyn  (bus_ssyn)
    );

    lck_line_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_raw),
        .pulse    (line_pulse)
    );

    lck_stat_reg u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (bus_init),
        .first (first),
        .sel   (sel),
        .is_wr (bus_wr),
        .wd6   (wdat6),
        .wd7   (wdat7),
        .pulse (line_pulse),
        .ie    (irq_enable),
        .rd6   (rdat6),
        .rd7   (rdat7)
    );

    // R8
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_msyn |-> (!rdat6 && !rdat7));

    // R11
    read_keeps_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_msyn && !bus_wr && !bus_init) |=> $stable(irq_enable));
endmodule

// File: tb/tb_lck_status_top.sv
`timescale 1ns/1ps
module tb_lck_status_top;
    localparam int DLY = 4;
    localparam logic [17:0] GOOD = 18'o777546;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [17:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_msyn = 1'b0, bus_init = 1'b0;
    logic wdat6 = 1'b0, wdat7 = 1'b0, line_raw = 1'b0;
    logic rdat6, rdat7, bus_ssyn, line_pulse, irq_enable;

    always #2.5 clk = ~clk;

    lck_status_top #(.SSYN_DLY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_msyn(bus_msyn), .bus_init(bus_init), .wdat6(wdat6), .wdat7(wdat7),
        .line_raw(line_raw), .rdat6(rdat6), .rdat7(rdat7), .bus_ssyn(bus_ssyn),
        .line_pulse(line_pulse), .irq_enable(irq_enable)
    );

    // observed vector: [4]=irq_enable [3]=ssyn [2]=pulse [1]=rdat7 [0]=rdat6
    typedef struct {
        string      req;
        logic [4:0] mask;
        logic [4:0] val;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit m_ie, m_mon;

    task automatic push(input string req, input logic [4:0] mask, input logic [4:0] val);
        exp_t e;
        e.req = req; e.mask = mask; e.val = val;
        q.push_back(e);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        logic [4:0] obs;
        obs = {irq_enable, bus_ssyn, line_pulse, rdat7, rdat6};
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if ((obs & e.mask) !== (e.val & e.mask)) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b (mask %b)", e.req, obs & e.mask,
                         e.val & e.mask, e.mask);
            end
        end
    end

    // full transfer: drive, check read data and slave-sync timing, release
    task automatic xfer(input bit wr, input logic [17:0] a, input bit w6, input bit w7,
                        input string req);
        bit hit;
        logic [1:0] rd;
        hit = (a[17:1] == GOOD[17:1]);
        rd  = (hit && !wr) ? {m_mon, m_ie} : 2'b00;
        cyc();
        bus_addr = a; bus_wr = wr; wdat6 = w6; wdat7 = w7; bus_msyn = 1'b1;
        push({req, " R8 data"}, 5'b01011, {3'b000, rd});
        if (hit && wr) begin
            m_ie = w6;
            if (!w7) m_mon = 1'b0;
        end
        for (int i = 1; i < DLY; i++) begin
            cyc();
            push({req, " R9 ssyn early"}, 5'b01000, 5'b00000);
        end
        cyc();
        push({req, " R9 ssyn due"}, 5'b01011, {1'b0, hit, 1'b0, rd});
        cyc();
        bus_msyn = 1'b0;
        push({req, " R9 ssyn hold R8 idle"}, 5'b01011, {1'b0, hit, 3'b000});
        cyc();
        push({req, " R9 ssyn release"}, 5'b01000, 5'b00000);
        push({req, " R12 enable out"}, 5'b10000, {m_ie, 4'b0000});
    endtask

    task automatic line_event(input string req);
        cyc();
        line_raw = 1'b1;
        push({req, " R4 no pulse yet"}, 5'b00100, 5'b00000);
        cyc();
        push({req, " R4 no pulse after 1 edge"}, 5'b00100, 5'b00000);
        cyc();
        push({req, " R4 pulse"}, 5'b00100, 5'b00100);
        cyc();
        push({req, " R4 single"}, 5'b00100, 5'b00000);
        m_mon = 1'b1;
        cyc();
        push({req, " R4 held high no pulse"}, 5'b00100, 5'b00000);
        line_raw = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_ie = 1'b0; m_mon = 1'b1;
        cyc();
        // R10 reset state
        push("R10 reset outputs", 5'b11100, 5'b00000);
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R10 reset read");

        // R2 R3: write enable with bit 7 = 1 keeps monitor
        xfer(1'b1, GOOD, 1'b1, 1'b1, "R2 write ie=1 w7=1");
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R3 monitor kept");
        // R3: clear monitor
        xfer(1'b1, GOOD, 1'b1, 1'b0, "R3 clear monitor");
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R3 readback");
        // R11: repeated read, no change
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R11 second read");

        // R1: odd byte address selects the same word
        xfer(1'b1, GOOD | 18'd1, 1'b0, 1'b1, "R1 byte bit ignored");
        xfer(1'b0, GOOD | 18'd1, 1'b0, 1'b0, "R1 odd read");
        // R1: neighbouring word is not selected
        xfer(1'b1, 18'o777544, 1'b1, 1'b0, "R1 wrong addr write");
        xfer(1'b0, 18'o777550, 1'b0, 1'b0, "R1 wrong addr read");
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R1 state untouched");

        // R4 R5: line event sets monitor
        line_event("R5 event");
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R5 monitor set");
        xfer(1'b1, GOOD, 1'b1, 1'b0, "R3 clear before collision");

        // R6: line pulse coincides with clearing write
        cyc();
        line_raw = 1'b1;
        cyc();
        cyc();
        push("R6 pulse present", 5'b00100, 5'b00100);
        bus_addr = GOOD; bus_wr = 1'b1; wdat6 = 1'b1; wdat7 = 1'b0; bus_msyn = 1'b1;
        cyc();
        bus_msyn = 1'b0;
        m_ie = 1'b1; m_mon = 1'b1;
        push("R6 write took ie", 5'b10000, 5'b10000);
        for (int i = 0; i < DLY + 2; i++) cyc();
        line_raw = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R6 monitor survives");

        // R7: init beats a simultaneous write
        xfer(1'b1, GOOD, 1'b1, 1'b0, "R7 setup ie=1 mon=0");
        cyc();
        bus_init = 1'b1;
        bus_addr = GOOD; bus_wr = 1'b1; wdat6 = 1'b1; wdat7 = 1'b0; bus_msyn = 1'b1;
        cyc();
        bus_init = 1'b0; bus_msyn = 1'b0;
        m_ie = 1'b0; m_mon = 1'b1;
        push("R7 init clears enable", 5'b10000, 5'b00000);
        cyc();
        xfer(1'b0, GOOD, 1'b0, 1'b0, "R7 init state");

        repeat (3) cyc();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule